// File: doc/BRIEF.md
# Debounced Port Input Interrupt Unit

This block watches eight input pins and raises an interrupt when a pin makes a qualified transition. Each pin is brought into the clock domain by two flip-flops. It then passes through a glitch filter that advances only on a slow sampling strobe from a prescaler. The filtered value feeds an edge detector whose polarity is chosen per bit. A detected edge sets a sticky flag for that bit. Flags stay set until software writes a one to them.

A 3-bit filter code selects how many strobe periods a new level must persist before it is accepted. Code 0 switches the filter off, so the synchronized pin goes straight to the edge detector. A per-bit enable decides which flags drive the single level-type request `irq` to an external interrupt controller.

Software uses a small register interface with a write strobe and a separate combinational read port:

| Address | Contents |
|---|---|
| 0 | flags, write one to clear |
| 1 | enables |
| 2 | edge polarity |
| 3 | filter code |

Top module: `pin_debounce_irq`

## Requirements
- R1: After reset, the flags, the enables and the polarity bits read 0, the filter code reads 0, and `irq` is low.
- R2: With filter code 0, a pin level that is held for one strobe period passes through the synchronizer to the edge detector. No strobe is needed for this.
- R3: Filter code k (1..7) gives a window of N = 2^k strobe periods. A new level that is seen at N or fewer consecutive strobes is rejected and sets no flag.
- R4: A new level that is seen at N+1 consecutive strobes is accepted. Any level held for 2N strobe periods is always accepted.
- R5: While no strobe arrives, a nonzero filter code makes no progress, and a pin change sets no flag.
- R6: Writing the filter code (address 3, bits [2:0]) restarts every bit's count. The write alone never changes the filtered value, and counting starts again from zero afterwards.
- R7: Polarity bit i (address 2) selects the edge that sets flag i: 0 selects rising, 1 selects falling.
- R8: Writing address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R9: If an edge on a bit arrives in the same cycle as a clear of that bit, the flag ends up set.
- R10: A flag can be set while its enable is 0. `irq` is high exactly while some flag and its enable bit (address 1) are both 1. It stays high until software clears the flag or drops the enable.
- R11: `rd_data` returns flags, enables, polarity and code for `rd_addr` 0, 1, 2 and 3. The code is in bits [2:0] with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler sampling strobe, one clock wide |
| pin_in | input | 8 | Raw asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Level interrupt request |

## Verification
The filter is driven with pulses whose length is counted in strobes, and every length sits next to a window boundary. At each filter code, a pulse of N strobes must be rejected and a pulse of N+1 strobes must pass, which pins down both the window length and the off-by-one in the count. A 2N-strobe pulse confirms the upper bound on acceptance.

Further patterns each isolate one rule:
- a pin held with no strobe at all shows that a missing strobe stalls the filter;
- rewriting the code in the middle of a pulse shows that the count restarts;
- a clear that lands in the same cycle as an edge shows that the set takes priority;
- flags raised while disabled show the masking and level behaviour of the request.

// File: rtl/pin_debounce_irq.sv
module pin_debounce_irq #(
  parameter int W      = 8,
  parameter int CODE_W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] pin_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam int MAX_SHIFT = (1 << CODE_W) - 1;
  localparam int CNT_W     = MAX_SHIFT + 1;

  logic [W-1:0]      s1, s2, filt, filt_d, flag, mask, esel, hit;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt [W];
  logic [CNT_W-1:0]  limit;

  wire wr_flag = wr_en && wr_addr == 2'd0;
  wire wr_mask = wr_en && wr_addr == 2'd1;
  wire wr_esel = wr_en && wr_addr == 2'd2;
  wire wr_code = wr_en && wr_addr == 2'd3;

  assign limit = CNT_W'(1) << code;
  assign hit   = (filt ^ filt_d) & (filt ^ esel);
  assign irq   = |(flag & mask);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = flag;
      2'd1:    rd_data = mask;
      2'd2:    rd_data = esel;
      default: rd_data = W'(code);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= '0;
      for (int i = 0; i < W; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (wr_code) begin
          cnt[i] <= '0;
        end else if (code == '0) begin
          cnt[i]  <= '0;
          filt[i] <= s2[i];
        end else if (tick) begin
          if (s2[i] == filt[i]) begin
            cnt[i] <= '0;
          end else if (cnt[i] == limit) begin
            cnt[i]  <= '0;
            filt[i] <= s2[i];
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_d <= '0;
      flag   <= '0;
      mask   <= '0;
      esel   <= '0;
      code   <= '0;
    end else begin
      filt_d <= filt;
      flag   <= (flag & ~(wr_flag ? wr_data : '0)) | hit;
      if (wr_mask) mask <= wr_data;
      if (wr_esel) esel <= wr_data;
      if (wr_code) code <= wr_data[CODE_W-1:0];
    end
  end

  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0 && !tick && !wr_code) |=> $stable(filt));

  a_r6_code_write_keeps_filt: assert property (@(posedge clk) disable iff (!rst_n)
    wr_code |=> $stable(filt));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> (($past(flag) & ~flag) == '0));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag & $past(hit)) == $past(hit)));

  for (genvar g = 0; g < W; g++) begin : g_cnt_chk
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= limit);
  end
endmodule

// File: tb/pin_debounce_irq_tb.sv
module pin_debounce_irq_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [7:0] pin_in = '0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_debounce_irq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  localparam int NV = 12;
  localparam int VCODE [NV] = '{1, 1, 1, 2, 2, 3, 3, 3, 4, 4, 0, 2};
  localparam int VLEN  [NV] = '{1, 2, 3, 4, 5, 8, 9, 16, 16, 17, 1, 8};
  localparam int VEXP  [NV] = '{0, 0, 1, 0, 1, 0, 1, 1, 0, 1, 1, 1};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ticks(int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk); @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, d); check("R1 flags", d, 8'h00);
    rd(1, d); check("R1 mask", d, 8'h00);
    rd(2, d); check("R1 esel", d, 8'h00);
    rd(3, d); check("R1 code", d, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = (VCODE[v] == 0) ? 1 : (1 << VCODE[v]);
      wr(3, 8'(VCODE[v]));
      wr(0, 8'hFF);
      @(negedge clk);
      pin_in = 8'hFF;
      ticks(VLEN[v]);
      pin_in = 8'h00;
      ticks(2 * n + 4);
      rd(0, d);
      if (VCODE[v] == 0)
        check("R2 bypass", d, 8'hFF);
      else if (VEXP[v] != 0)
        check("R4 accept", d, 8'hFF);
      else
        check("R3 reject", d, 8'h00);
    end

    wr(3, 8'd1);
    wr(0, 8'hFF);
    @(negedge clk);
    pin_in = 8'h01;
    repeat (60) @(negedge clk);
    rd(0, d); check("R5 no tick", d, 8'h00);
    pin_in = 8'h00;
    ticks(8);
    wr(0, 8'hFF);

    wr(3, 8'd3);
    wr(0, 8'hFF);
    @(negedge clk);
    pin_in = 8'h02;
    ticks(6);
    wr(3, 8'd3);
    ticks(6);
    rd(0, d); check("R6 restart", d, 8'h00);
    ticks(3);
    rd(0, d); check("R6 after restart", d, 8'h02);
    pin_in = 8'h00;
    ticks(20);

    wr(3, 8'd0);
    wr(0, 8'hFF);
    wr(2, 8'h01);
    rd(2, d); check("R11 esel read", d, 8'h01);
    @(negedge clk);
    pin_in = 8'h03;
    repeat (6) @(negedge clk);
    rd(0, d); check("R7 rising", d, 8'h02);
    pin_in = 8'h00;
    repeat (6) @(negedge clk);
    rd(0, d); check("R7 falling", d, 8'h03);
    wr(2, 8'h00);

    wr(0, 8'h01);
    rd(0, d); check("R8 w1c partial", d, 8'h02);
    wr(0, 8'h00);
    rd(0, d); check("R8 write zero", d, 8'h02);

    check("R10 masked irq", {7'b0, irq}, 8'h00);
    wr(1, 8'h02);
    rd(1, d); check("R11 mask read", d, 8'h02);
    repeat (5) @(negedge clk);
    check("R10 irq held", {7'b0, irq}, 8'h01);
    wr(0, 8'h02);
    check("R10 irq cleared", {7'b0, irq}, 8'h00);
    wr(1, 8'h00);

    wr(0, 8'hFF);
    @(negedge clk);
    pin_in = 8'h02;
    repeat (6) @(negedge clk);
    @(negedge clk);
    pin_in = 8'h03;
    @(negedge clk); @(negedge clk); @(negedge clk);
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'h03;
    @(negedge clk);
    wr_en = 0;
    rd(0, d); check("R9 set wins", d, 8'h01);

    wr(3, 8'hFD);
    rd(3, d); check("R11 code read", d, 8'h05);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule